// File: doc/BRIEF.md
# Shift-Register Reload Clock Divider

This block divides its input clock in three places using programmable ratios. A 6-bit reference stage and an 8-bit feedback stage each walk a fixed shift-register sequence instead of counting in binary. When a stage reaches its terminal state it loads a programmed reload value and flips its output. The division ratio is set by where in the sequence the reload value sits. A chain of two binary post-dividers, each set from 1 to 8, produces a third output. Its toggle spacing is the product of the two divisors.

Software programs the three ratios through a small write port. A select code picks the reference reload, the feedback reload or the packed post-divider word. The post-divider fields use an inverted encoding: each field holds eight minus the divisor. A new value never shortens or stretches an interval that is already in progress. It takes effect at the next reload of the stage, or at the end of the full post-divider period. This lets software reprogram the block while it runs without causing a glitch, including the two-write sequence used when a post-divisor of 8 is selected.

Top module: `lfsr_pll_divider`

## Requirements
- R1: While reset is asserted all three outputs are low. The reset values are reference reload 0x3F (divide by 1), feedback reload 0x00 (divide by 2) and post word 0x3F (1 x 1). Every stage starts in its terminal state, so all three outputs go high on the first clock edge after reset is released.
- R2: The reference stage is 6 bits wide and its terminal state is 0x3F. Except in the terminal state, the next state is the current state shifted left by one with XNOR(bit5, bit4) entering at bit 0. The one exception is state 0x00, which is followed by 0x3F. In the terminal state the stage loads its reload value and toggles its output. Reload values 0x3F, 0x00, 0x28 and 0x01 give a toggle spacing of 1, 2, 5 and 64 cycles.
- R3: The feedback stage is 8 bits wide and its terminal state is 0x01, which is the state that follows 0x00. Its next state is a left shift with XNOR(bit7, bit3, bit2, bit1) entering at bit 0. Its reload and toggle behaviour is the same as in R2. Reload values 0x00, 0x80, 0x6E and 0x69 give a toggle spacing of 2, 3, 40 and 160 cycles.
- R4: A reload write does not change the interval in progress. The new spacing starts with the interval that follows the next terminal event.
- R5: In the post word, bits 2:0 hold 8 minus the first divisor P1 and bits 5:3 hold 8 minus the second divisor P2. A field value of 0 means 8. The post output toggles every P1 x P2 cycles.
- R6: A post word takes effect only at the end of the current post output interval. If several words are written within one interval, only the last one is used. For example, 0x39 followed by 0x30 gives the spacing of 0x30.
- R7: Select code 0 writes the reference reload from data bits 5:0. Code 1 writes the feedback reload from data bits 7:0. Code 2 writes the post word from data bits 5:0. Code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_sel | input | 2 | Register select: 0 reference, 1 feedback, 2 post word, 3 none |
| cfg_wdata | input | 8 | Write data |
| ref_div_o | output | 1 | Reference stage output, toggles at each reload |
| fb_div_o | output | 1 | Feedback stage output, toggles at each reload |
| post_div_o | output | 1 | Post-divider chain output |

## Verification
The bench builds the block with its default parameters: a 6-bit reference stage, an 8-bit feedback stage and 3-bit post fields. At these sizes the bench's model can search the full state space of each sequence, so it can turn any divisor into a reload value and any reload value into a divisor. The extremes are therefore within reach: divide by 1 and by 64 on the reference stage, divide by 160 on the feedback stage, and the 64-cycle post period. A write made in the middle of a long interval shows the change landing at the boundary. Divisor 8, with its two-write sequence, exercises the field value 0.

// File: rtl/lfsr_div_pkg.sv
`timescale 1ns/1ps
package lfsr_div_pkg;

    typedef enum logic [1:0] {
        SEL_REF  = 2'd0,
        SEL_FB   = 2'd1,
        SEL_POST = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lfsr_reload_stage.sv
`timescale 1ns/1ps
module lfsr_reload_stage #(
    parameter int           W          = 6,
    parameter logic [W-1:0] TAPS       = 6'h30,
    parameter logic [W-1:0] TERM       = 6'h3F,
    parameter logic [W-1:0] RST_RELOAD = 6'h3F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    output logic         div_o
);

    logic [W-1:0] lfsr_q;
    logic [W-1:0] lfsr_d;
    logic [W-1:0] reload_q;
    logic         at_term;
    logic         fb_bit;

    // Next-state: reload at terminal, forced jump from all-zero, else shift.
    always_comb begin
        at_term = (lfsr_q == TERM);
        fb_bit  = ~^(lfsr_q & TAPS);
        if (at_term) begin
            lfsr_d = reload_q;
        end else if (lfsr_q == '0) begin
            lfsr_d = TERM;
        end else begin
            lfsr_d = {lfsr_q[W-2:0], fb_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q   <= TERM;
            reload_q <= RST_RELOAD;
            div_o    <= 1'b0;
        end else begin
            lfsr_q <= lfsr_d;
            if (at_term) begin
                div_o <= ~div_o;
            end
            if (load_we) begin
                reload_q <= load_val;
            end
        end
    end

    // R2 / R3: output flips exactly on terminal cycles
    a_r2_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        at_term |=> (div_o != $past(div_o)));

    a_r2_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !at_term |=> $stable(div_o));

    // R4: the reload register moves only on a write
    a_r4_reload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_we |=> $stable(reload_q));

endmodule

// File: rtl/post_div_chain.sv
`timescale 1ns/1ps
module post_div_chain #(
    parameter int              FW      = 3,
    parameter logic [2*FW-1:0] RST_CFG = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2*FW-1:0] cfg_val,
    output logic            div_o
);

    localparam int CW = 2 * FW;

    logic [CW-1:0] cfg_q;
    logic [FW-1:0] f1_q;
    logic [FW-1:0] f2_q;
    logic [FW-1:0] cnt1_q;
    logic [FW-1:0] cnt2_q;
    logic          tick1;
    logic          wrap;

    always_comb begin
        tick1 = (cnt1_q == '0);
        wrap  = tick1 && (cnt2_q == '0);
    end

    // Field f encodes divisor 2**FW - f, so the count start is ~f.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= RST_CFG;
            f1_q   <= RST_CFG[FW-1:0];
            f2_q   <= RST_CFG[CW-1:FW];
            cnt1_q <= '0;
            cnt2_q <= '0;
            div_o  <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q <= cfg_val;
            end
            if (wrap) begin
                f1_q   <= cfg_q[FW-1:0];
                f2_q   <= cfg_q[CW-1:FW];
                cnt1_q <= ~cfg_q[FW-1:0];
                cnt2_q <= ~cfg_q[CW-1:FW];
                div_o  <= ~div_o;
            end else if (tick1) begin
                cnt1_q <= ~f1_q;
                cnt2_q <= cnt2_q - 1'b1;
            end else begin
                cnt1_q <= cnt1_q - 1'b1;
            end
        end
    end

    // R5: output flips only at the end of the full chain period
    a_r5_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (div_o != $past(div_o)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(div_o));

    // R6: active fields change only at a period boundary
    a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(f1_q) && $stable(f2_q)));

endmodule

// File: rtl/lfsr_pll_divider.sv
`timescale 1ns/1ps
module lfsr_pll_divider
    import lfsr_div_pkg::*;
#(
    parameter int                REF_W      = 6,
    parameter logic [REF_W-1:0]  REF_TAPS   = 6'h30,
    parameter logic [REF_W-1:0]  REF_TERM   = 6'h3F,
    parameter logic [REF_W-1:0]  REF_RST    = 6'h3F,
    parameter int                FB_W       = 8,
    parameter logic [FB_W-1:0]   FB_TAPS    = 8'h8E,
    parameter logic [FB_W-1:0]   FB_TERM    = 8'h01,
    parameter logic [FB_W-1:0]   FB_RST     = 8'h00,
    parameter int                PD_W       = 3,
    parameter logic [2*PD_W-1:0] PD_RST     = '1,
    localparam int               CFG_W      = max3(REF_W, FB_W, 2 * PD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             ref_div_o,
    output logic             fb_div_o,
    output logic             post_div_o
);

    cfg_sel_e sel;
    logic     ref_we;
    logic     fb_we;
    logic     post_we;

    always_comb begin
        sel     = cfg_sel_e'(cfg_sel);
        ref_we  = cfg_we && (sel == SEL_REF);
        fb_we   = cfg_we && (sel == SEL_FB);
        post_we = cfg_we && (sel == SEL_POST);
    end

    // R7: at most one register is written per cycle
    a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_we, fb_we, post_we}));

    lfsr_reload_stage #(
        .W          (REF_W),
        .TAPS       (REF_TAPS),
        .TERM       (REF_TERM),
        .RST_RELOAD (REF_RST)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_we  (ref_we),
        .load_val (cfg_wdata[REF_W-1:0]),
        .div_o    (ref_div_o)
    );

    lfsr_reload_stage #(
        .W          (FB_W),
        .TAPS       (FB_TAPS),
        .TERM       (FB_TERM),
        .RST_RELOAD (FB_RST)
    ) u_fb (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_we  (fb_we),
        .load_val (cfg_wdata[FB_W-1:0]),
        .div_o    (fb_div_o)
    );

    post_div_chain #(
        .FW      (PD_W),
        .RST_CFG (PD_RST)
    ) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (post_we),
        .cfg_val (cfg_wdata[2*PD_W-1:0]),
        .div_o   (post_div_o)
    );

endmodule

// File: tb/lfsr_pll_divider_tb.sv
`timescale 1ns/1ps
module lfsr_pll_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       ref_div_o, fb_div_o, post_div_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    lfsr_pll_divider u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ref_div_o  (ref_div_o),
        .fb_div_o   (fb_div_o),
        .post_div_o (post_div_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Sequence rules taken from R2 and R3
    function automatic int seq_next(input int w, input int taps, input int term, input int s);
        int mask;
        mask = (1 << w) - 1;
        if (s == 0) return term;
        return ((s << 1) & mask) | ((^(s & taps)) ? 0 : 1);
    endfunction

    function automatic int seq_div(input int w, input int taps, input int term, input int r);
        int n;
        int s;
        n = 1;
        s = r;
        while (s != term && n <= (1 << w) + 1) begin
            s = seq_next(w, taps, term, s);
            n++;
        end
        return n;
    endfunction

    function automatic int find_reload(input int w, input int taps, input int term, input int d);
        for (int s = 0; s < (1 << w); s++) begin
            if (seq_div(w, taps, term, s) == d) return s;
        end
        return 0;
    endfunction

    function automatic int post_div(input int v);
        int f1, f2;
        f1 = v & 7;
        f2 = (v >> 3) & 7;
        return (8 - f1) * (8 - f2);
    endfunction

    function automatic int ref_div(input int r);
        return seq_div(6, 'h30, 'h3F, r);
    endfunction

    function automatic int fb_div(input int r);
        return seq_div(8, 'h8E, 'h01, r);
    endfunction

    // Behavioural model: cycles remaining to the next toggle, per output
    int   m_cnt [3] = '{0, 0, 0};
    logic m_out [3] = '{1'b0, 1'b0, 1'b0};
    int   m_ref  = 'h3F;
    int   m_fb   = 'h00;
    int   m_post = 'h3F;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0;
                m_out[i] = 1'b0;
            end
            m_ref = 'h3F; m_fb = 'h00; m_post = 'h3F;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (m_cnt[i] == 0) begin
                    m_out[i] = ~m_out[i];
                    case (i)
                        0: m_cnt[i] = ref_div(m_ref) - 1;
                        1: m_cnt[i] = fb_div(m_fb) - 1;
                        default: m_cnt[i] = post_div(m_post) - 1;
                    endcase
                end else begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_ref  = int'(cfg_wdata[5:0]);
                    2'd1: m_fb   = int'(cfg_wdata);
                    2'd2: m_post = int'(cfg_wdata[5:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R2 ref, R3 fb, R5 post)
    always @(negedge clk) begin
        if (!done) begin
            check(int'(ref_div_o),  int'(m_out[0]), "R2 ref output vs model");
            check(int'(fb_div_o),   int'(m_out[1]), "R3 fb output vs model");
            check(int'(post_div_o), int'(m_out[2]), "R5 post output vs model");
        end
    end

    function automatic logic pick(input int idx);
        case (idx)
            0: return ref_div_o;
            1: return fb_div_o;
            default: return post_div_o;
        endcase
    endfunction

    task automatic wait_toggle(input int idx);
        logic p;
        p = pick(idx);
        do @(negedge clk); while (pick(idx) == p);
    endtask

    task automatic meas(input int idx, output int gap);
        int t0;
        wait_toggle(idx);
        t0 = cyc;
        wait_toggle(idx);
        gap = cyc - t0;
    endtask

    task automatic wr(input logic [1:0] sel, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data[7:0];
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic set_and_check(input int idx, input logic [1:0] sel, input int data,
                                 input int exp, input string tag);
        int g;
        wr(sel, data);
        meas(idx, g);
        check(g, exp, tag);
    endtask

    task automatic mid_write(input int idx, input logic [1:0] sel, input int d1, input int d2,
                             input bit two, input int e_old, input int e_new, input string tag);
        int t0, t1, t2;
        wait_toggle(idx);
        t0 = cyc;
        wr(sel, d1);
        if (two) wr(sel, d2);
        wait_toggle(idx);
        t1 = cyc;
        wait_toggle(idx);
        t2 = cyc;
        check(t1 - t0, e_old, {tag, " interval in progress"});
        check(t2 - t1, e_new, {tag, " following interval"});
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int g;
        int r;
        repeat (4) @(negedge clk);
        // R1: outputs low in reset
        check(int'(ref_div_o),  0, "R1 ref low in reset");
        check(int'(fb_div_o),   0, "R1 fb low in reset");
        check(int'(post_div_o), 0, "R1 post low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(ref_div_o),  1, "R1 ref high after first edge");
        check(int'(fb_div_o),   1, "R1 fb high after first edge");
        check(int'(post_div_o), 1, "R1 post high after first edge");
        meas(0, g); check(g, 1, "R1 default ref spacing");
        meas(1, g); check(g, 2, "R1 default fb spacing");
        meas(2, g); check(g, 1, "R1 default post spacing");

        // R2: reference stage divisors
        set_and_check(0, 2'd0, 'h28, 5,  "R2 reload 0x28");
        set_and_check(0, 2'd0, 'h01, 64, "R2 reload 0x01");
        set_and_check(0, 2'd0, 'h00, 2,  "R2 reload 0x00");
        set_and_check(0, 2'd0, 'h3F, 1,  "R2 reload 0x3F");
        foreach (g_list_ref[i]) begin
            r = find_reload(6, 'h30, 'h3F, g_list_ref[i]);
            set_and_check(0, 2'd0, r, g_list_ref[i], "R2 searched reload");
        end

        // R3: feedback stage divisors
        set_and_check(1, 2'd1, 'h80, 3,   "R3 reload 0x80");
        set_and_check(1, 2'd1, 'h6E, 40,  "R3 reload 0x6E");
        set_and_check(1, 2'd1, 'h69, 160, "R3 reload 0x69");
        set_and_check(1, 2'd1, 'h00, 2,   "R3 reload 0x00");
        foreach (g_list_fb[i]) begin
            r = find_reload(8, 'h8E, 'h01, g_list_fb[i]);
            set_and_check(1, 2'd1, r, g_list_fb[i], "R3 searched reload");
        end

        // R4: a write in mid-interval lands at the next terminal event
        set_and_check(0, 2'd0, 'h01, 64, "R4 setup");
        mid_write(0, 2'd0, 'h28, 0, 1'b0, 64, 5, "R4 ref");
        set_and_check(1, 2'd1, 'h69, 160, "R4 setup fb");
        mid_write(1, 2'd1, 'h80, 0, 1'b0, 160, 3, "R4 fb");

        // R5: post encoding, field 0 means 8
        set_and_check(2, 2'd2, 'h00, 64, "R5 post 8x8");
        set_and_check(2, 2'd2, 'h35, 6,  "R5 post 3x2");
        set_and_check(2, 2'd2, 'h38, 8,  "R5 post 8x1");
        set_and_check(2, 2'd2, 'h1B, 25, "R5 post 5x5");

        // R6: two-step write inside one interval, only the last counts
        set_and_check(2, 2'd2, 'h00, 64, "R6 setup");
        mid_write(2, 2'd2, 'h39, 'h30, 1'b1, 64, 16, "R6 post");

        // R7: select code 3 changes nothing
        set_and_check(0, 2'd0, 'h28, 5, "R7 setup ref");
        set_and_check(1, 2'd1, 'h80, 3, "R7 setup fb");
        wr(2'd3, 'h3F);
        meas(0, g); check(g, 5,  "R7 ref unchanged by select 3");
        meas(1, g); check(g, 3,  "R7 fb unchanged by select 3");
        meas(2, g); check(g, 16, "R7 post unchanged by select 3");

        done = 1'b1;
        summary();
        $finish;
    end

    int g_list_ref [3] = '{7, 13, 33};
    int g_list_fb  [2] = '{17, 99};

endmodule